// File: doc/BRIEF.md
# Multicycle Stored-Program Sequencer

This block is the control and datapath core of a small accumulator machine in which program and data occupy one memory. A word becomes an instruction only by being fetched at the program counter. All memory traffic goes through two internal registers. The first is an address register that drives the memory address. The second is a buffer register that captures every word read and supplies every word written. The sequencer performs one micro-operation per clock. The steps are: fetch, counter advance, decode, address formation, operand read, execute and write-back. Steps an opcode does not need are skipped, so instruction latency depends on the opcode class.

The memory port is single-ported and synchronous. The address register is loaded on one edge, the memory returns the word on the next edge, and the sequencer captures it into the buffer register on the edge after that. A write is a single-cycle strobe with the address and buffer register on the bus. Debug outputs show the program counter, the instruction register and the accumulator. A dedicated opcode stops the machine.

Instruction word: bits 15:12 hold the opcode and bits 11:0 hold an address field. Opcodes: 0 load, 1 store, 2 add, 3 subtract, 4 AND, 5 OR, 6 complement, 7 jump, 8 branch-if-zero, 15 halt, 9 to 14 no operation.

Top module: `stored_prog_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction register, accumulator, zero flag and both memory registers. It lowers halt and the write strobe. The first fetch after reset is from address 0.
- R2: Each instruction is fetched from the address held in the program counter. The fetched word appears in the instruction register. The program counter then advances by one, modulo 4096.
- R3: Latency from one fetch to the next is fixed by opcode class. Load, add, subtract, AND and OR (memory operand) take 9 cycles. Store takes 8 cycles. Complement, jump and branch take 6 cycles. Opcodes 9 to 14 take 5 cycles. The accumulator keeps its old value until the last cycle of the instruction.
- R4: Add and subtract combine the accumulator with the word at the address field, modulo 2^16. AND and OR combine the same two words bitwise. Complement inverts the accumulator without any memory read. Load copies the addressed word.
- R5: The zero flag is written only by add, subtract, AND, OR and complement, and is set exactly when their result is 0. Load, store, jump, branch and no-operation opcodes leave it unchanged.
- R6: Store raises the write strobe for exactly one cycle. During that cycle the address equals the address field and the write data equals the accumulator. No other opcode writes memory.
- R7: Jump loads the address field into the program counter.
- R8: Branch-if-zero loads the address field into the program counter when the zero flag is set. Otherwise it leaves the incremented program counter and has no other effect.
- R9: Opcode 15 raises halt five cycles after its fetch begins. While halt is high, the program counter, instruction register and accumulator hold, and no write occurs, until reset.
- R10: A word written by a store is fetched and executed as an instruction when the program counter reaches its address.
- R11: Opcodes 9 to 14 change nothing except advancing the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| halt | output | 1 | Machine stopped |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_acc | output | 16 | Accumulator |

## Verification
On every cycle the assertions check the following. The write strobe is a single-cycle pulse carrying the instruction's address field and the accumulator. The fetch address equals the program counter. The counter steps by exactly one in the advance state. The accumulator moves only in the execute state and the instruction register only in the advance state. Halt is sticky, freezes the visible state and blocks writes. Arithmetic results, branch decisions on the zero flag, per-class latency, opcodes that do nothing and the execution of freshly stored words are shown only by the bench's programs. The bench runs them against an instruction-level model.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int unsigned SPS_OP_W   = 4;
    localparam int unsigned SPS_ADDR_W = 12;

    typedef enum logic [SPS_OP_W-1:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_ADD   = 4'h2,
        OP_SUB   = 4'h3,
        OP_AND   = 4'h4,
        OP_OR    = 4'h5,
        OP_NOT   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_BRZ   = 4'h8,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_FWAIT,
        S_FREAD,
        S_ADVANCE,
        S_DECODE,
        S_ADDR,
        S_OWAIT,
        S_OREAD,
        S_EXEC,
        S_STORE,
        S_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_INV
    } alu_op_e;

    typedef struct packed {
        logic mar_ld;
        logic mar_from_pc;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic ir_ld;
        logic pc_inc;
        logic pc_ld;
        logic acc_ld;
        logic z_ld;
    } dp_ctrl_t;

    function automatic logic op_reads_mem(input opcode_e op);
        case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic op_sets_flag(input opcode_e op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    function automatic logic op_reg_only(input opcode_e op);
        case (op)
            OP_NOT, OP_JUMP, OP_BRZ: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic alu_op_e op_to_alu(input opcode_e op);
        case (op)
            OP_ADD:  return ALU_ADD;
            OP_SUB:  return ALU_SUB;
            OP_AND:  return ALU_AND;
            OP_OR:   return ALU_OR;
            OP_NOT:  return ALU_INV;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/sps_alu.sv
module sps_alu
    import sps_pkg::*;
#(
    parameter int unsigned DATA_W = 16
)(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_INV: y = ~a;
            default: y = b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
    import sps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SPS_OP_W-1:0] opcode,
    input  logic                zero_flag,
    output state_e              state,
    output dp_ctrl_t            dp,
    output alu_op_e             alu_op,
    output logic                mem_we,
    output logic                halt
);

    opcode_e op;
    state_e  nxt;

    assign op = opcode_e'(opcode);

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        case (state)
            S_FETCH:   nxt = S_FWAIT;
            S_FWAIT:   nxt = S_FREAD;
            S_FREAD:   nxt = S_ADVANCE;
            S_ADVANCE: nxt = S_DECODE;
            S_DECODE: begin
                if (op == OP_HALT)
                    nxt = S_HALT;
                else if (op_reads_mem(op) || op == OP_STORE)
                    nxt = S_ADDR;
                else if (op_reg_only(op))
                    nxt = S_EXEC;
                else
                    nxt = S_FETCH;
            end
            S_ADDR:    nxt = (op == OP_STORE) ? S_EXEC : S_OWAIT;
            S_OWAIT:   nxt = S_OREAD;
            S_OREAD:   nxt = S_EXEC;
            S_EXEC:    nxt = (op == OP_STORE) ? S_STORE : S_FETCH;
            S_STORE:   nxt = S_FETCH;
            S_HALT:    nxt = S_HALT;
            default:   nxt = S_FETCH;
        endcase
    end

    always_comb begin
        dp     = '0;
        alu_op = ALU_PASS;
        mem_we = 1'b0;
        halt   = 1'b0;
        case (state)
            S_FETCH: begin
                dp.mar_ld      = 1'b1;
                dp.mar_from_pc = 1'b1;
            end
            S_FREAD:   dp.mbr_from_mem = 1'b1;
            S_ADVANCE: begin
                dp.ir_ld  = 1'b1;
                dp.pc_inc = 1'b1;
            end
            S_ADDR:    dp.mar_ld = 1'b1;
            S_OREAD:   dp.mbr_from_mem = 1'b1;
            S_EXEC: begin
                alu_op = op_to_alu(op);
                case (op)
                    OP_STORE: dp.mbr_from_acc = 1'b1;
                    OP_JUMP:  dp.pc_ld = 1'b1;
                    OP_BRZ:   dp.pc_ld = zero_flag;
                    default: begin
                        dp.acc_ld = op_reads_mem(op) || op_sets_flag(op);
                        dp.z_ld   = op_sets_flag(op);
                    end
                endcase
            end
            S_STORE:   mem_we = 1'b1;
            S_HALT:    halt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sps_dpath.sv
module sps_dpath
    import sps_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  dp_ctrl_t          c,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_y,
    input  logic              alu_zero,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] acc,
    output logic              zf
);

    logic [ADDR_W-1:0] field;
    assign field = ir[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            mar <= '0;
            mbr <= '0;
            acc <= '0;
            zf  <= 1'b0;
        end else begin
            if (c.mar_ld)
                mar <= c.mar_from_pc ? pc : field;
            if (c.mbr_from_mem)
                mbr <= mem_rdata;
            else if (c.mbr_from_acc)
                mbr <= acc;
            if (c.ir_ld)
                ir <= mbr;
            if (c.pc_ld)
                pc <= field;
            else if (c.pc_inc)
                pc <= pc + 1'b1;
            if (c.acc_ld)
                acc <= alu_y;
            if (c.z_ld)
                zf <= alu_zero;
        end
    end

endmodule

// File: rtl/stored_prog_seq.sv
module stored_prog_seq
    import sps_pkg::*;
#(
    parameter int unsigned ADDR_W = SPS_ADDR_W,
    localparam int unsigned DATA_W = SPS_OP_W + ADDR_W
)(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halt,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_ir,
    output logic [DATA_W-1:0] dbg_acc
);

    state_e            st;
    dp_ctrl_t          dpc;
    alu_op_e           aop;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] acc;
    logic              zf;
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;

    sps_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .opcode    (ir[DATA_W-1 -: SPS_OP_W]),
        .zero_flag (zf),
        .state     (st),
        .dp        (dpc),
        .alu_op    (aop),
        .mem_we    (mem_we),
        .halt      (halt)
    );

    sps_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (aop),
        .a    (acc),
        .b    (mbr),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sps_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .c         (dpc),
        .mem_rdata (mem_rdata),
        .alu_y     (alu_y),
        .alu_zero  (alu_zero),
        .pc        (pc),
        .ir        (ir),
        .mar       (mar),
        .mbr       (mbr),
        .acc       (acc),
        .zf        (zf)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign dbg_pc    = pc;
    assign dbg_ir    = ir;
    assign dbg_acc   = acc;

endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
)(
    input logic              clk,
    input logic              rst,
    input state_e            st,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              halt,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [DATA_W-1:0] dbg_ir,
    input logic [DATA_W-1:0] dbg_acc
);

    // R1: reset leaves a cleared, running machine
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && dbg_acc == '0 && dbg_ir == '0 && !halt && !mem_we));

    // R2: memory sees the program counter while a fetch is waiting
    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_FWAIT) |-> (mem_addr == dbg_pc));

    // R2: counter steps by one in the advance state
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_ADVANCE) |=> (dbg_pc == (ADDR_W)'($past(dbg_pc) + 1'b1)));

    // R2: instruction register changes only in the advance state
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st != S_ADVANCE) |=> $stable(dbg_ir));

    // R3: accumulator changes only in the execute state
    p_acc_exec_only_r3: assert property (@(posedge clk) disable iff (rst)
        (st != S_EXEC) |=> $stable(dbg_acc));

    // R6: write strobe is a single-cycle pulse
    p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R6: write carries the address field and the accumulator
    p_we_payload_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == dbg_ir[ADDR_W-1:0] && mem_wdata == dbg_acc));

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R9: halted machine holds its visible state
    p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        halt |=> ($stable(dbg_pc) && $stable(dbg_acc)));

    // R9: no write while halted
    p_halt_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

endmodule

bind stored_prog_seq sps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halt      (halt),
    .dbg_pc    (dbg_pc),
    .dbg_ir    (dbg_ir),
    .dbg_acc   (dbg_acc)
);

// File: tb/stored_prog_seq_test.sv
module stored_prog_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata = '0;
    logic        halt;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ir;
    logic [15:0] dbg_acc;

    int vectors = 0;
    int fails   = 0;

    // environment memory driven by the design
    logic [15:0] ram [0:255];
    // reference model state
    logic [15:0] mmem [0:255];
    bit          written [0:255];
    logic [11:0] m_pc;
    logic [15:0] m_acc;
    bit          m_z;
    bit          m_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    stored_prog_seq uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halt      (halt),
        .dbg_pc    (dbg_pc),
        .dbg_ir    (dbg_ir),
        .dbg_acc   (dbg_acc)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[7:0]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        ram[a]  = w;
        mmem[a] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            ram[i]     = '0;
            mmem[i]    = '0;
            written[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc",   dbg_pc,  '0);
        chk("R1", "acc",  dbg_acc, '0);
        chk("R1", "ir",   dbg_ir,  '0);
        chk("R1", "halt", halt,    '0);
        chk("R1", "we",   mem_we,  '0);
        m_pc = '0; m_acc = '0; m_z = 1'b0; m_halt = 1'b0;
        rst = 1'b0;
    endtask

    // runs the loaded program against the instruction-level model
    task automatic run(input int max_instr);
        int n = 0;
        while (!m_halt && n < max_instr) begin
            logic [15:0] ins;
            logic [3:0]  op;
            logic [11:0] fld;
            logic [11:0] n_pc;
            logic [15:0] n_acc;
            logic [15:0] opnd;
            bit          n_z;
            int          lat;
            string       tag;
            bit          is_st;
            ins   = mmem[m_pc[7:0]];
            op    = ins[15:12];
            fld   = ins[11:0];
            opnd  = mmem[fld[7:0]];
            n_pc  = m_pc + 12'd1;
            n_acc = m_acc;
            n_z   = m_z;
            is_st = 1'b0;
            case (op)
                4'h0: begin lat = 9; n_acc = opnd; tag = "R4"; end
                4'h1: begin lat = 8; is_st = 1'b1; tag = "R6"; end
                4'h2: begin lat = 9; n_acc = m_acc + opnd; n_z = (n_acc == 0); tag = "R4"; end
                4'h3: begin lat = 9; n_acc = m_acc - opnd; n_z = (n_acc == 0); tag = "R4"; end
                4'h4: begin lat = 9; n_acc = m_acc & opnd; n_z = (n_acc == 0); tag = "R4"; end
                4'h5: begin lat = 9; n_acc = m_acc | opnd; n_z = (n_acc == 0); tag = "R4"; end
                4'h6: begin lat = 6; n_acc = ~m_acc; n_z = (n_acc == 0); tag = "R4"; end
                4'h7: begin lat = 6; n_pc = fld; tag = "R7"; end
                4'h8: begin lat = 6; if (m_z) n_pc = fld; tag = "R5 R8"; end
                4'hF: begin lat = 5; tag = "R9"; end
                default: begin lat = 5; tag = "R11"; end
            endcase
            for (int j = 0; j < lat; j++) begin
                chk(tag, "we", mem_we, (is_st && j == lat - 1));
                if (is_st && j == lat - 1) begin
                    chk("R6", "waddr", mem_addr,  fld);
                    chk("R6", "wdata", mem_wdata, m_acc);
                end
                if (j == 1) chk("R2", "fetch addr", mem_addr, m_pc);
                if (j == lat - 1) chk("R3", "acc early", dbg_acc, m_acc);
                chk("R9", "halt early", halt, 1'b0);
                @(negedge clk);
            end
            if (is_st) begin
                mmem[fld[7:0]]    = m_acc;
                written[fld[7:0]] = 1'b1;
            end
            chk(written[m_pc[7:0]] ? "R10" : "R2", "ir", dbg_ir, ins);
            m_acc = n_acc;
            m_z   = n_z;
            m_pc  = n_pc;
            chk((op == 4'h7 || op == 4'h8) ? tag : "R3", "pc", dbg_pc, m_pc);
            chk(tag, "acc", dbg_acc, m_acc);
            if (op == 4'hF) begin
                m_halt = 1'b1;
                chk("R9", "halt", halt, 1'b1);
            end
            n++;
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9", "halt hold", halt,    1'b1);
            chk("R9", "pc hold",   dbg_pc,  m_pc);
            chk("R9", "acc hold",  dbg_acc, m_acc);
            chk("R9", "no write",  mem_we,  1'b0);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=halt");
        summary();
    end

    initial begin
        clear_mem();
        // program one: every opcode, wraparound, branches both ways, self-modifying store
        put(0,  16'h0020);  // load 5
        put(1,  16'h2021);  // +3 -> 8
        put(2,  16'h3022);  // -8 -> 0, zero set
        put(3,  16'h8005);  // branch taken
        put(4,  16'hF000);  // skipped
        put(5,  16'h0023);  // load 00F0
        put(6,  16'h4024);  // and 0F30 -> 0030
        put(7,  16'h5025);  // or 0102 -> 0132
        put(8,  16'h8004);  // branch not taken
        put(9,  16'h6000);  // invert -> FECD
        put(10, 16'h1030);  // store to 0x30
        put(11, 16'h0030);  // reload it
        put(12, 16'h0026);  // load 7011 (a jump word)
        put(13, 16'h100E);  // store it over address 14
        put(14, 16'hF000);  // overwritten before fetch
        put(17, 16'h6000);  // invert 7011 -> 8FEE
        put(18, 16'h2027);  // + 7012 -> 0000 wrap, zero set
        put(19, 16'h9000);  // no-op opcode
        put(20, 16'h8016);  // branch taken to 22
        put(21, 16'hF000);
        put(22, 16'h6000);  // invert 0 -> FFFF
        put(23, 16'h8000);  // not taken
        put(24, 16'hF000);  // halt
        put(8'h20, 16'h0005);
        put(8'h21, 16'h0003);
        put(8'h22, 16'h0008);
        put(8'h23, 16'h00F0);
        put(8'h24, 16'h0F30);
        put(8'h25, 16'h0102);
        put(8'h26, 16'h7011);
        put(8'h27, 16'h7012);
        do_reset();
        run(100);
        chk("R6",  "ram 0x30", ram[8'h30], mmem[8'h30]);
        chk("R10", "ram 0x0E", ram[8'h0E], 16'h7011);

        // program two: flag survives load and no-op, jump, halt at end
        clear_mem();
        put(0, 16'h0010);   // load 00FF
        put(1, 16'h4011);   // and FF00 -> 0, zero set
        put(2, 16'hA123);   // no-op opcode
        put(3, 16'h0010);   // load 00FF, flag stays set
        put(4, 16'h8006);   // branch taken
        put(5, 16'hF000);
        put(6, 16'h7008);   // jump
        put(7, 16'hF000);
        put(8, 16'hE000);   // no-op opcode
        put(9, 16'hF000);   // halt
        put(8'h10, 16'h00FF);
        put(8'h11, 16'hFF00);
        do_reset();
        run(100);
        summary();
    end

endmodule